// File: doc/BRIEF.md
# Three-Wire Serial Voice Memory Interface

This block is the master end of a three-wire link to an external serial memory that holds voice data. A playback engine hands it a 24-bit start address with a one-cycle start pulse. The block shifts the address out on the data line, timed by a dedicated address strobe. It then releases the data line and pulls voice bits back in on the same line, timed by a separate read strobe. Each group of eight bits is offered to the playback engine as one byte on a valid/ready handshake. Reading runs on, byte after byte, until a stop request is taken at a byte boundary.

The high and low phases of both strobes last a programmable number of system clocks, sampled at the start pulse. When the float option is set, the block releases both strobe lines and the data line to high impedance while no playback is running. When the option is clear, the idle lines are driven low. The data line is brought out as a separate input, output and output enable, and both strobes share one output enable, so the pad ring builds the bidirectional pins.

Top module: `vsm_link`

## Requirements
- R1: After reset, busy_o, adr_clk_o, rd_clk_o and byte_valid_o are all 0.
- R2: After a start pulse, exactly 24 address-strobe pulses are issued. The address goes out MSB first, one bit per pulse. dat_o changes only while adr_clk_o is low, and dat_oe_o is 1 whenever adr_clk_o is 1.
- R3: The first rising edge of rd_clk_o comes exactly L+1 system clocks after the last falling edge of adr_clk_o. dat_oe_o is 0 from that falling edge on.
- R4: Every high phase and every low phase of either strobe lasts L system clocks. L is phase_len_i sampled at the start pulse, and a value of 0 is taken as 1.
- R5: Read bits are sampled at each rising edge of rd_clk_o and assembled MSB first. Each group of 8 bits is presented as one byte on byte_o with byte_valid_o high.
- R6: While byte_valid_o is 1 and byte_ready_i is 0, byte_o holds its value. Once a further byte has been completed and cannot be stored, no further rd_clk_o pulses occur until the held byte is taken. No byte is lost.
- R7: busy_o rises after the start pulse and stays 1 until a stop request is accepted at the next byte boundary. The byte being read when stop arrives is still delivered. A stop during the address phase takes effect after the first byte.
- R8: A start pulse while busy_o is 1 is ignored. The address, phase length and data stream of the running transfer are unchanged.
- R9: While idle with tristate_en_i = 1, clk_oe_o and dat_oe_o are 0. While idle with tristate_en_i = 0, they are 1 and adr_clk_o, rd_clk_o and dat_o are 0.
- R10: While busy_o is 1, clk_oe_o is 1. dat_oe_o is 0 whenever rd_clk_o is 1.
- R11: adr_clk_o and rd_clk_o are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin a playback read |
| start_addr_i | input | ADDR_W (24) | Start bit address in the external memory |
| stop_i | input | 1 | One-cycle request to end reading at the next byte boundary |
| tristate_en_i | input | 1 | Float all link lines while idle when 1 |
| phase_len_i | input | PHASE_W | Strobe phase length in system clocks (0 taken as 1) |
| byte_o | output | BYTE_W (8) | Assembled voice data byte |
| byte_valid_o | output | 1 | byte_o holds an untaken byte |
| byte_ready_i | input | 1 | Playback engine takes the byte this cycle |
| busy_o | output | 1 | Transfer in progress |
| adr_clk_o | output | 1 | Address strobe to the memory |
| rd_clk_o | output | 1 | Read strobe to the memory |
| clk_oe_o | output | 1 | Output enable for both strobe pads |
| dat_o | output | 1 | Data line value driven by the master |
| dat_oe_o | output | 1 | Data line output enable |
| dat_i | input | 1 | Data line value seen at the pad |

## Verification
The bench builds the block with a 24-bit address, 8-bit bytes and a 3-bit phase length. This allows phase lengths from the clamped zero up to 7 clocks, and a full address phase plus several bytes fits in a few hundred cycles. A behavioural memory model captures the address bits on address-strobe rising edges and presents computed data bits after each read-strobe falling edge. This makes the address order, the turnaround gap, the back-pressure stall and stops in the address, read and stalled phases all observable at the ports.

// File: rtl/vsm_pkg.sv
package vsm_pkg;

  // Transfer sequencing states of the link master
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,   // no transfer, lines parked or floating
    ST_ADDR = 3'd1,   // address bits going out
    ST_TURN = 3'd2,   // data line released, no strobe
    ST_READ = 3'd3,   // read strobe running, bits coming in
    ST_WAIT = 3'd4    // byte complete, output slot occupied
  } vsm_state_e;

  localparam int NUM_STROBES = 2;
  localparam int STB_ADR     = 0;
  localparam int STB_RD      = 1;

endpackage

// File: rtl/vsm_strobe.sv
module vsm_strobe #(
  parameter int PHASE_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run_i,
  input  logic [PHASE_W-1:0] len_i,
  output logic               lvl_o,
  output logic               rise_o,
  output logic               fall_o
);

  localparam logic [PHASE_W-1:0] ONE = PHASE_W'(1);

  logic [PHASE_W-1:0] cnt_q;
  logic               last_w;

  // Phase ends after len_i cycles; len_i is never 0 here
  assign last_w = (cnt_q == (len_i - ONE));
  assign rise_o = run_i && last_w && !lvl_o;
  assign fall_o = run_i && last_w && lvl_o;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
      lvl_o <= 1'b0;
    end else if (last_w) begin
      cnt_q <= '0;
      lvl_o <= !lvl_o;
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end

endmodule

// File: rtl/vsm_addr_ser.sv
module vsm_addr_ser #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              shift_i,
  output logic              bit_o,
  output logic              done_o
);

  localparam int CNT_W = $clog2(ADDR_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_W - 1);

  logic [ADDR_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  assign bit_o  = sh_q[ADDR_W-1];
  assign done_o = shift_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= addr_i;
      cnt_q <= '0;
    end else if (shift_i) begin
      // zero fill leaves the line low once the address is out
      sh_q  <= {sh_q[ADDR_W-2:0], 1'b0};
      cnt_q <= done_o ? '0 : cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/vsm_byte_des.sv
module vsm_byte_des #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              sample_i,
  input  logic              bit_i,
  input  logic              fall_i,
  input  logic              push_i,
  input  logic              ready_i,
  output logic              byte_end_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              valid_o
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  assign byte_end_o = fall_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (sample_i) sh_q <= {sh_q[BYTE_W-2:0], bit_i};
      if (fall_i)   cnt_q <= byte_end_o ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else if (push_i) begin
      data_o  <= sh_q;
      valid_o <= 1'b1;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  // R6: an offered byte stays put until taken
  a_r6_hold_byte: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));

  // R6: a byte is only stored when the slot is free
  a_r6_no_overwrite: assert property (@(posedge clk) disable iff (rst)
    push_i |-> (!valid_o || ready_i));

endmodule

// File: rtl/vsm_link.sv
module vsm_link
  import vsm_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int BYTE_W  = 8,
  parameter int PHASE_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [ADDR_W-1:0]  start_addr_i,
  input  logic               stop_i,
  input  logic               tristate_en_i,
  input  logic [PHASE_W-1:0] phase_len_i,
  output logic [BYTE_W-1:0]  byte_o,
  output logic               byte_valid_o,
  input  logic               byte_ready_i,
  output logic               busy_o,
  output logic               adr_clk_o,
  output logic               rd_clk_o,
  output logic               clk_oe_o,
  output logic               dat_o,
  output logic               dat_oe_o,
  input  logic               dat_i
);

  localparam logic [PHASE_W-1:0] ONE = PHASE_W'(1);

  vsm_state_e st_q, st_nxt;

  logic [PHASE_W-1:0]     len_q;
  logic                   stop_pend_q;
  logic                   stop_now;
  logic                   accept;
  logic                   push;
  logic                   slot_free;
  logic                   addr_done;
  logic                   byte_end;
  logic [NUM_STROBES-1:0] stb_run, stb_lvl, stb_rise, stb_fall;

  assign accept    = (st_q == ST_IDLE) && start_i;
  assign stop_now  = stop_pend_q || stop_i;
  assign slot_free = !byte_valid_o || byte_ready_i;

  // ---------------------------------------------------------------
  // Strobe generators: one per strobe pin
  // ---------------------------------------------------------------
  assign stb_run[STB_ADR] = (st_q == ST_ADDR);
  assign stb_run[STB_RD]  = (st_q == ST_READ);

  for (genvar g = 0; g < NUM_STROBES; g++) begin : g_stb
    vsm_strobe #(.PHASE_W(PHASE_W)) stb_i (
      .clk    (clk),
      .rst    (rst),
      .run_i  (stb_run[g]),
      .len_i  (len_q),
      .lvl_o  (stb_lvl[g]),
      .rise_o (stb_rise[g]),
      .fall_o (stb_fall[g])
    );
  end

  assign adr_clk_o = stb_lvl[STB_ADR];
  assign rd_clk_o  = stb_lvl[STB_RD];

  // ---------------------------------------------------------------
  // Address out, bytes in
  // ---------------------------------------------------------------
  vsm_addr_ser #(.ADDR_W(ADDR_W)) ser_i (
    .clk     (clk),
    .rst     (rst),
    .load_i  (accept),
    .addr_i  (start_addr_i),
    .shift_i (stb_fall[STB_ADR]),
    .bit_o   (dat_o),
    .done_o  (addr_done)
  );

  vsm_byte_des #(.BYTE_W(BYTE_W)) des_i (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (accept),
    .sample_i   (stb_rise[STB_RD]),
    .bit_i      (dat_i),
    .fall_i     (stb_fall[STB_RD]),
    .push_i     (push),
    .ready_i    (byte_ready_i),
    .byte_end_o (byte_end),
    .data_o     (byte_o),
    .valid_o    (byte_valid_o)
  );

  // ---------------------------------------------------------------
  // Sequencer
  // ---------------------------------------------------------------
  always_comb begin
    st_nxt = st_q;
    push   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) st_nxt = ST_ADDR;
      ST_ADDR: if (addr_done) st_nxt = ST_TURN;
      ST_TURN: st_nxt = ST_READ;
      ST_READ: begin
        if (byte_end) begin
          if (slot_free) begin
            push   = 1'b1;
            st_nxt = stop_now ? ST_IDLE : ST_READ;
          end else begin
            st_nxt = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (slot_free) begin
          push   = 1'b1;
          st_nxt = stop_now ? ST_IDLE : ST_READ;
        end
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      len_q       <= ONE;
      stop_pend_q <= 1'b0;
      busy_o      <= 1'b0;
      clk_oe_o    <= 1'b0;
      dat_oe_o    <= 1'b0;
    end else begin
      st_q <= st_nxt;
      if (accept) len_q <= (phase_len_i == '0) ? ONE : phase_len_i;
      if (st_nxt == ST_IDLE)      stop_pend_q <= 1'b0;
      else if (st_q != ST_IDLE)   stop_pend_q <= stop_pend_q || stop_i;
      busy_o   <= (st_nxt != ST_IDLE);
      clk_oe_o <= (st_nxt != ST_IDLE) || !tristate_en_i;
      dat_oe_o <= (st_nxt == ST_ADDR) || ((st_nxt == ST_IDLE) && !tristate_en_i);
    end
  end

  // ---------------------------------------------------------------
  // Checks
  // ---------------------------------------------------------------
  a_r11_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(adr_clk_o && rd_clk_o));

  a_r2_drive_on_adr: assert property (@(posedge clk) disable iff (rst)
    (adr_clk_o || stb_rise[STB_ADR]) |-> dat_oe_o);

  a_r10_release_on_rd: assert property (@(posedge clk) disable iff (rst)
    rd_clk_o |-> !dat_oe_o);

  a_r10_strobes_driven: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> clk_oe_o);

  a_r7_stop_ends_busy: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> $past(stop_now));

  a_r6_pause_read: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT) |-> !rd_clk_o);

  a_r9_float_idle: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_IDLE) && $past(tristate_en_i)) |-> (!clk_oe_o && !dat_oe_o));

endmodule

// File: tb/vsm_link_tb_top.sv
module vsm_link_tb_top;

  localparam int AW = 24;
  localparam int BW = 8;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic          stop_i = 1'b0;
  logic          tristate_en_i = 1'b1;
  logic [PW-1:0] phase_len_i = '0;
  logic [BW-1:0] byte_o;
  logic          byte_valid_o;
  logic          byte_ready_i = 1'b1;
  logic          busy_o, adr_clk_o, rd_clk_o, clk_oe_o, dat_o, dat_oe_o;
  logic          dat_in;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  vsm_link #(.ADDR_W(AW), .BYTE_W(BW), .PHASE_W(PW)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .start_addr_i(start_addr_i),
    .stop_i(stop_i), .tristate_en_i(tristate_en_i), .phase_len_i(phase_len_i),
    .byte_o(byte_o), .byte_valid_o(byte_valid_o), .byte_ready_i(byte_ready_i),
    .busy_o(busy_o), .adr_clk_o(adr_clk_o), .rd_clk_o(rd_clk_o),
    .clk_oe_o(clk_oe_o), .dat_o(dat_o), .dat_oe_o(dat_oe_o), .dat_i(dat_in)
  );

  function automatic logic [7:0] exp_byte(input logic [23:0] a, input int n);
    logic [7:0] k;
    k = 8'((n * 59) + 90);
    return a[7:0] ^ a[15:8] ^ k;
  endfunction

  // ---------------- memory model ----------------
  logic [23:0] mdl_addr = '0;
  int mdl_abits = 0;
  int mdl_bit = 0;

  always @(posedge adr_clk_o) if (dat_oe_o) begin
    mdl_addr = {mdl_addr[22:0], dat_o};
    mdl_abits++;
  end
  always @(negedge rd_clk_o) mdl_bit++;
  always @* begin
    logic [7:0] b;
    b = exp_byte(mdl_addr, mdl_bit / 8);
    dat_in = b[7 - (mdl_bit % 8)];
  end

  // ---------------- monitor ----------------
  int cyc = 0, adr_hi_len = 0, last_adr_hi = 0, last_adr_fall = 0;
  int first_rd_rise = -1, rd_rises = 0, flag_both = 0, flag_oe = 0;
  logic rd_prev = 1'b0;
  logic [7:0] got [0:15];
  int ngot = 0;

  always @(posedge clk) begin
    cyc++;
    if (adr_clk_o) adr_hi_len++;
    else if (adr_hi_len > 0) begin
      last_adr_hi = adr_hi_len; adr_hi_len = 0; last_adr_fall = cyc;
    end
    if (rd_clk_o && !rd_prev) begin
      rd_rises++;
      if (first_rd_rise < 0) first_rd_rise = cyc;
    end
    rd_prev = rd_clk_o;
    if (adr_clk_o && rd_clk_o) flag_both++;
    if (rd_clk_o && dat_oe_o) flag_oe++;
    if (!rst && byte_valid_o && byte_ready_i && ngot < 16) begin
      got[ngot] = byte_o; ngot++;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic launch(input logic [23:0] a, input logic [PW-1:0] len);
    @(negedge clk);
    mdl_bit = 0; mdl_abits = 0; ngot = 0; first_rd_rise = -1;
    start_addr_i = a; phase_len_i = len; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
  endtask

  task automatic wait_bytes(input int n);
    while (ngot < n) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(busy_o == 0, "R1 busy", busy_o, 0);
    chk(adr_clk_o == 0 && rd_clk_o == 0, "R1 strobes", {adr_clk_o, rd_clk_o}, 0);
    chk(byte_valid_o == 0, "R1 valid", byte_valid_o, 0);
    chk(clk_oe_o == 0 && dat_oe_o == 0, "R9 float at idle", {clk_oe_o, dat_oe_o}, 0);
  endtask

  task automatic t_basic();
    logic [23:0] a = 24'hA5C31E;
    launch(a, 3'd2);
    wait_bytes(2);
    pulse_stop();
    wait_idle();
    chk(mdl_addr == a, "R2 address MSB first", mdl_addr, a);
    chk(mdl_abits == 24, "R2 address pulses", mdl_abits, 24);
    chk(last_adr_hi == 2, "R4 high phase", last_adr_hi, 2);
    chk(first_rd_rise - last_adr_fall == 3, "R3 turnaround", first_rd_rise - last_adr_fall, 3);
    chk(ngot == 3, "R7 in-flight byte delivered", ngot, 3);
    for (int i = 0; i < 3; i++)
      chk(got[i] == exp_byte(a, i), "R5 byte data", got[i], exp_byte(a, i));
    chk(flag_both == 0, "R11 strobes overlap", flag_both, 0);
    chk(flag_oe == 0, "R10 data driven in read", flag_oe, 0);
  endtask

  task automatic t_stop_in_addr();
    logic [23:0] a = 24'h0F00FF;
    launch(a, 3'd1);
    pulse_stop();
    repeat (10) @(negedge clk);
    chk(busy_o == 1, "R7 busy held through address", busy_o, 1);
    wait_idle();
    chk(ngot == 1, "R7 stop in address gives one byte", ngot, 1);
    chk(got[0] == exp_byte(a, 0), "R5 first byte", got[0], exp_byte(a, 0));
  endtask

  task automatic t_stall();
    logic [23:0] a = 24'h123456;
    logic [7:0] held;
    int rr;
    @(negedge clk); byte_ready_i = 1'b0;
    launch(a, 3'd1);
    repeat (300) @(negedge clk);
    chk(byte_valid_o == 1, "R6 valid held", byte_valid_o, 1);
    chk(byte_o == exp_byte(a, 0), "R6 held byte", byte_o, exp_byte(a, 0));
    held = byte_o; rr = rd_rises;
    repeat (100) @(negedge clk);
    chk(rd_rises == rr, "R6 read strobe paused", rd_rises - rr, 0);
    chk(byte_o == held, "R6 byte stable", byte_o, held);
    byte_ready_i = 1'b1; stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
    wait_idle();
    chk(ngot == 2, "R7 stop while stalled", ngot, 2);
    chk(got[1] == exp_byte(a, 1), "R6 no byte lost", got[1], exp_byte(a, 1));
  endtask

  task automatic t_ignore_start();
    logic [23:0] a = 24'h89ABCD;
    launch(a, 3'd3);
    repeat (20) @(negedge clk);
    start_addr_i = 24'h111111; phase_len_i = 3'd1; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    wait_bytes(1);
    pulse_stop();
    wait_idle();
    chk(mdl_abits == 24, "R8 no extra address pulses", mdl_abits, 24);
    chk(mdl_addr == a, "R8 address kept", mdl_addr, a);
    chk(last_adr_hi == 3, "R8 phase length kept", last_adr_hi, 3);
    chk(got[0] == exp_byte(a, 0), "R8 data stream kept", got[0], exp_byte(a, 0));
  endtask

  task automatic t_lengths();
    launch(24'h3C3C3C, 3'd0);
    wait_bytes(1); pulse_stop(); wait_idle();
    chk(last_adr_hi == 1, "R4 zero length taken as one", last_adr_hi, 1);
    chk(first_rd_rise - last_adr_fall == 2, "R3 turnaround L1", first_rd_rise - last_adr_fall, 2);
    launch(24'hC0FFEE, 3'd7);
    wait_bytes(1); pulse_stop(); wait_idle();
    chk(last_adr_hi == 7, "R4 long phase", last_adr_hi, 7);
    chk(got[0] == exp_byte(24'hC0FFEE, 0), "R5 byte at long phase", got[0], exp_byte(24'hC0FFEE, 0));
  endtask

  task automatic t_tristate();
    @(negedge clk); tristate_en_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(clk_oe_o == 1 && dat_oe_o == 1, "R9 driven idle", {clk_oe_o, dat_oe_o}, 2'b11);
    chk(dat_o == 0 && adr_clk_o == 0 && rd_clk_o == 0, "R9 idle levels low",
        {dat_o, adr_clk_o, rd_clk_o}, 0);
    tristate_en_i = 1'b1;
    repeat (2) @(negedge clk);
    chk(clk_oe_o == 0 && dat_oe_o == 0, "R9 floated idle", {clk_oe_o, dat_oe_o}, 0);
    launch(24'h5A5A5A, 3'd1);
    repeat (2) @(negedge clk);
    chk(clk_oe_o == 1 && dat_oe_o == 1, "R10 driven in address", {clk_oe_o, dat_oe_o}, 2'b11);
    while (rd_rises == 0 || first_rd_rise < 0) @(negedge clk);
    chk(clk_oe_o == 1 && dat_oe_o == 0, "R10 read direction", {clk_oe_o, dat_oe_o}, 2'b10);
    pulse_stop();
    wait_idle();
    chk(clk_oe_o == 0 && dat_oe_o == 0, "R9 floated after stop", {clk_oe_o, dat_oe_o}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R7 watchdog actual=hung expected=idle");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_stop_in_addr();
    t_stall();
    t_ignore_start();
    t_lengths();
    t_tristate();
    chk(flag_both == 0, "R11 strobes overlap overall", flag_both, 0);
    chk(flag_oe == 0, "R10 data released overall", flag_oe, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule